// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital, device-side half of a 16-bit successive-approximation converter's serial port. It watches a conversion-start line, a serial clock and a serial data input, all asynchronous to its own system clock, and presents the converted result on a serial data output with a separate output-enable. The sample value itself arrives on a parallel test port and is captured at the start of each conversion. A cycle counter stands in for the conversion time.

One rising edge of the start line does two things at once. It begins a conversion, and it fixes the port's personality for that conversion from the level of the serial input. With the serial input high, the port behaves as a selectable device. The output is enabled only while the start line or the serial input is low, and a busy flag is shown if the device was already selected when the conversion ended. With the serial input low, the port becomes one link of a daisy chain. Its result leaves through a 16-bit shift path while upstream data enters behind it. An optional completion flag is passed from the serial input to the serial output before the shifting begins.

Top module: `sar_serial_port`

## Requirements
- R1: After reset the output-enable is low and no conversion is running.
- R2: A rising edge on the synchronized start line begins a conversion lasting CONV_CYCLES system clocks. Whenever the output is enabled during that time it reads 0.
- R3: The interface mode is taken from the synchronized serial input at the start edge. A low level selects chain mode and a high level selects select mode.
- R4: In select mode the output-enable is high only while the synchronized start line or serial input is low.
- R5: In select mode, if the device is selected on the cycle the conversion ends, the output reads 1 until the first serial clock falling edge. The 16 data bits follow after that edge.
- R6: In select mode without the busy flag, bit 15 of the result is on the output as soon as the conversion ends. Each following serial clock falling edge advances one bit, most significant first, in straight binary.
- R7: In select mode the output-enable falls after the falling edge that moves past bit 0.
- R8: In chain mode the output is always enabled. The serial input level present at a falling edge reappears on the output 16 falling edges later, behind the device's own 16-bit result.
- R9: In chain mode, if the serial input is low on the cycle the conversion ends, the output follows the serial input level until the first falling edge. No data bit is consumed by that edge.
- R10: Serial clock falling edges that occur while a conversion runs shift nothing.
- R11: A start edge during a shift-out discards the unsent bits. Only the new result is read out afterwards.
- R12: Each of the three serial lines passes through a two-stage synchronizer, so a level change reaches the outputs two system clock edges after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_in | input | 1 | Conversion-start line, asynchronous |
| sck_in | input | 1 | Serial clock, asynchronous; data advances on its falling edge |
| sdi_in | input | 1 | Serial data input / mode select / select line |
| sample_in | input | 16 | Parallel sample value captured at the start edge |
| sdo_out | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output-enable for the serial output (low means high impedance) |

## Verification
A wrong mode latch shows at once after the conversion. The output-enable stays high in chain mode, or follows the select condition in select mode, so the mismatch appears within one cycle of the conversion's end. A wrong bit counter or shift register shows in the serial word read back: a bit lost or repeated shifts the word after 16 falling edges, and an early or late enable drop shows on the edge after bit 0. A wrong conversion counter moves the first valid data bit or busy flag by a cycle or more. A behavioural model compares the enable and data on every clock, so such a shift is caught in the cycle it happens.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

  typedef enum logic {
    MODE_SELECT = 1'b0,
    MODE_CHAIN  = 1'b1
  } port_mode_e;

  // Mode picked at the start edge from the serial input level (R3)
  function automatic port_mode_e mode_from_sdi(input logic sdi_level);
    return sdi_level ? MODE_SELECT : MODE_CHAIN;
  endfunction

  // Select-mode device enable: either line low (R4)
  function automatic logic cs_selected(input logic cnv_level, input logic sdi_level);
    return !cnv_level || !sdi_level;
  endfunction

  // Whether a completion flag precedes the data (R5, R9)
  function automatic logic flag_at_done(input port_mode_e mode,
                                        input logic cnv_level,
                                        input logic sdi_level);
    return (mode == MODE_CHAIN) ? !sdi_level : cs_selected(cnv_level, sdi_level);
  endfunction

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic edge_pulse
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];

  generate
    if (FALLING) begin : g_fall
      assign edge_pulse = !pipe[STAGES-1] && pipe[STAGES];
    end else begin : g_rise
      assign edge_pulse = pipe[STAGES-1] && !pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start) begin
      active <= 1'b1;
      remain <= CW'(CYCLES - 1);
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign done = active && (remain == '0) && !start;
endmodule

// File: rtl/sar_shift_core.sv
module sar_shift_core
  import sar_port_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  sample,
  input  logic          cnv_lvl,
  input  logic          sdi_lvl,
  input  logic          conv_active,
  input  logic          conv_done,
  input  logic          sck_fall,
  output port_mode_e    mode,
  output logic          flag,
  output logic [BW-1:0] bits_left,
  output logic          msb,
  output logic          select
);
  logic [W-1:0] shreg;
  logic         shift_ok;

  assign select   = cs_selected(cnv_lvl, sdi_lvl);
  assign shift_ok = sck_fall && !conv_active && (mode == MODE_CHAIN || select);
  assign msb      = shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_SELECT;
      flag      <= 1'b0;
      bits_left <= '0;
      shreg     <= '0;
    end else if (start) begin
      mode      <= mode_from_sdi(sdi_lvl);
      shreg     <= sample;
      bits_left <= '0;
      flag      <= 1'b0;
    end else if (conv_done) begin
      bits_left <= BW'(W);
      flag      <= flag_at_done(mode, cnv_lvl, sdi_lvl);
    end else if (shift_ok) begin
      if (flag) begin
        flag <= 1'b0;
      end else if (mode == MODE_CHAIN) begin
        shreg <= {shreg[W-2:0], sdi_lvl};
      end else if (bits_left != '0) begin
        shreg     <= {shreg[W-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnv_in,
  input  logic         sck_in,
  input  logic         sdi_in,
  input  logic [W-1:0] sample_in,
  output logic         sdo_out,
  output logic         sdo_oe
);
  localparam int BW = $clog2(W + 1);

  logic          cnv_lvl, cnv_rise;
  logic          sck_lvl, sck_fall;
  logic          sdi_lvl, sdi_rise;
  logic          conv_active, conv_done;
  port_mode_e    port_mode;
  logic          mode_chain;
  logic          flag;
  logic [BW-1:0] bits_left;
  logic          msb;
  logic          select;

  sar_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_cnv_sync (
    .clk(clk), .rst_n(rst_n), .din(cnv_in), .level(cnv_lvl), .edge_pulse(cnv_rise));

  sar_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sck_in), .level(sck_lvl), .edge_pulse(sck_fall));

  sar_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .din(sdi_in), .level(sdi_lvl), .edge_pulse(sdi_rise));

  sar_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cnv_rise),
    .active(conv_active), .done(conv_done));

  sar_shift_core #(.W(W), .BW(BW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(cnv_rise), .sample(sample_in),
    .cnv_lvl(cnv_lvl), .sdi_lvl(sdi_lvl),
    .conv_active(conv_active), .conv_done(conv_done), .sck_fall(sck_fall),
    .mode(port_mode), .flag(flag), .bits_left(bits_left), .msb(msb), .select(select));

  assign mode_chain = (port_mode == MODE_CHAIN);

  always_comb begin
    sdo_oe  = 1'b0;
    sdo_out = 1'b0;
    if (mode_chain) begin
      sdo_oe = 1'b1;
      if (conv_active)  sdo_out = 1'b0;
      else if (flag)    sdo_out = sdi_lvl;
      else              sdo_out = msb;
    end else if (conv_active) begin
      sdo_oe = select;
    end else if (flag) begin
      sdo_oe  = select;
      sdo_out = select;
    end else if (bits_left != '0) begin
      sdo_oe  = select;
      sdo_out = select && msb;
    end
  end
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
  parameter int W  = 16,
  parameter int BW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdo_out,
  input logic          sdo_oe,
  input logic          cnv_rise,
  input logic          sck_fall,
  input logic          sdi_rise,
  input logic          sck_lvl,
  input logic          conv_active,
  input logic          conv_done,
  input logic          select,
  input logic          mode_chain,
  input logic          flag,
  input logic [BW-1:0] bits_left
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sdo_oe);

  a_r2_quiet_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && sdo_oe) |-> !sdo_out);

  a_r2_done_ends_conv: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_active);

  a_r4_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chain && sdo_oe) |-> select);

  a_r5_flag_only_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(conv_done));

  a_r6_hold_without_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv_rise && !conv_done && !sck_fall) |=> $stable(bits_left));

  a_r7_bits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= BW'(W));

  a_r8_chain_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chain |-> sdo_oe);

  a_r9_flag_follows_sdi: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chain && flag && !conv_active && sdi_rise) |-> sdo_out);

  a_r10_no_shift_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && (sck_fall || sck_lvl)) |-> (bits_left == '0 && !flag));

  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise |=> (conv_active && bits_left == '0 && !flag));
endmodule

bind sar_serial_port sar_serial_port_chk #(.W(W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
  .cnv_rise(cnv_rise), .sck_fall(sck_fall), .sdi_rise(sdi_rise), .sck_lvl(sck_lvl),
  .conv_active(conv_active), .conv_done(conv_done), .select(select),
  .mode_chain(mode_chain), .flag(flag), .bits_left(bits_left));

// File: tb/sim_sar_serial_port.sv
module sim_sar_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int CONV       = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnv = 1'b0, sck = 1'b0, sdi = 1'b1;
  logic [W-1:0] sample = '0;
  logic         sdo_out, sdo_oe;

  sar_serial_port #(.W(W), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .cnv_in(cnv), .sck_in(sck), .sdi_in(sdi),
    .sample_in(sample), .sdo_out(sdo_out), .sdo_oe(sdo_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done_run = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: synchronizer stages, a countdown and a bit queue
  bit       m_c1, m_c2, m_cd, m_k1, m_k2, m_kd, m_d1, m_d2;
  int       m_cnt;
  bit       m_chain, m_flag;
  bit [W-1:0] m_sample;
  bit       pend[$];

  always @(posedge clk) begin : model
    bit rise, fall, sel;
    if (!rst_n) begin
      {m_c1, m_c2, m_cd, m_k1, m_k2, m_kd, m_d1, m_d2} = '0;
      m_cnt = 0; m_chain = 0; m_flag = 0; m_sample = '0;
      pend.delete();
    end else begin
      rise = m_c2 && !m_cd;
      fall = !m_k2 && m_kd;
      sel  = !m_c2 || !m_d2;
      if (rise) begin
        m_cnt = CONV; m_chain = !m_d2; m_sample = sample; m_flag = 0;
        pend.delete();
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_flag = m_chain ? !m_d2 : sel;
          pend.delete();
          for (int i = W-1; i >= 0; i--) pend.push_back(m_sample[i]);
        end
      end else if (fall && (m_chain || sel)) begin
        if (m_flag) m_flag = 0;
        else if (m_chain) begin
          void'(pend.pop_front());
          pend.push_back(m_d2);
        end else if (pend.size() > 0) void'(pend.pop_front());
      end
      m_cd = m_c2; m_c2 = m_c1; m_c1 = cnv;
      m_kd = m_k2; m_k2 = m_k1; m_k1 = sck;
      m_d2 = m_d1; m_d1 = sdi;
    end
  end

  always @(negedge clk) begin : compare
    bit eoe, esdo, sel;
    if (rst_n && !done_run) begin
      sel = !m_c2 || !m_d2;
      eoe = 0; esdo = 0;
      if (m_chain) begin
        eoe = 1;
        if (m_cnt > 0)   esdo = 0;
        else if (m_flag) esdo = m_d2;
        else             esdo = pend.size() > 0 ? pend[0] : 1'b0;
      end else if (m_cnt > 0) begin
        eoe = sel;
      end else if (m_flag) begin
        eoe = sel; esdo = 1;
      end else if (pend.size() > 0) begin
        eoe = sel; esdo = pend[0];
      end
      check(sdo_oe === eoe, cur_req, "model oe", sdo_oe, eoe);
      if (eoe) check(sdo_out === esdo, cur_req, "model sdo", sdo_out, esdo);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic pulse(input bit din);
    sdi = din; sck = 1'b1; step(4);
    sck = 1'b0; step(4);
  endtask

  task automatic read_word(output logic [W-1:0] w, input bit din);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      w[W-1-i] = sdo_out;
      pulse(din);
    end
  endtask

  logic [W-1:0] got, got2;
  localparam logic [W-1:0] UPSTREAM = 16'hC5E9;

  initial begin
    // R1: reset state
    step(5); rst_n = 1'b1; step(3);
    @(negedge clk);
    check(sdo_oe === 1'b0, "R1", "oe after reset", sdo_oe, 0);

    // R3, R4, R6, R7: select mode, not selected during conversion, no busy flag
    cur_req = "R6"; sample = 16'hB38D;
    cnv = 1'b1; step(CONV + 6);
    @(negedge clk);
    check(sdo_oe === 1'b0, "R4", "oe while unselected", sdo_oe, 0);
    step(0); cnv = 1'b0; step(3);
    @(negedge clk);
    check(sdo_oe === 1'b1, "R3", "select mode enable", sdo_oe, 1);
    check(sdo_out === 1'b1, "R6", "D15 at once", sdo_out, 1);
    step(0); read_word(got, 1'b1);
    check(got === 16'hB38D, "R6", "select word", got, 16'hB38D);
    @(negedge clk);
    check(sdo_oe === 1'b0, "R7", "high-Z after last bit", sdo_oe, 0);
    step(0); cnv = 1'b1; step(CONV + 6);

    // R5, R10, R12: busy flag; falls during conversion ignored; sync latency
    cur_req = "R5"; sample = 16'h4C71;
    cnv = 1'b0; step(4); cnv = 1'b1; step(4);
    cnv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sdo_oe === 1'b0, "R12", "oe one edge after select", sdo_oe, 0);
    @(negedge clk);
    check(sdo_oe === 1'b1, "R12", "oe two edges after select", sdo_oe, 1);
    check(sdo_out === 1'b0, "R2", "busy low in conversion", sdo_out, 0);
    step(0); pulse(1'b1); pulse(1'b1);
    step(CONV);
    @(negedge clk);
    check(sdo_out === 1'b1 && sdo_oe === 1'b1, "R5", "completion flag", sdo_out, 1);
    step(0); pulse(1'b1);
    read_word(got, 1'b1);
    check(got === 16'h4C71, "R10", "word intact after conversion falls", got, 16'h4C71);

    // R11: restart mid shift-out
    cur_req = "R11"; sample = 16'h9E2B;
    cnv = 1'b1; step(2); cnv = 1'b0; step(CONV + 4);
    pulse(1'b1);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    sample = 16'h1357;
    cnv = 1'b1; step(4); cnv = 1'b0; step(CONV + 4);
    pulse(1'b1);
    read_word(got, 1'b1);
    check(got === 16'h1357, "R11", "only new word after restart", got, 16'h1357);

    // R3, R8: chain mode without flag, pass-through after 16 falls
    cur_req = "R8"; sdi = 1'b0; step(4);
    sample = 16'h6AD4;
    cnv = 1'b1; step(4);
    sdi = 1'b1; step(CONV + 4);
    @(negedge clk);
    check(sdo_oe === 1'b1, "R3", "chain mode enable", sdo_oe, 1);
    step(0);
    for (int i = 0; i < 2*W; i++) begin
      @(negedge clk);
      if (i < W) got[W-1-i] = sdo_out; else got2[2*W-1-i] = sdo_out;
      pulse(i < W ? UPSTREAM[W-1-i] : 1'b0);
    end
    check(got === 16'h6AD4, "R8", "own word in chain", got, 16'h6AD4);
    check(got2 === UPSTREAM, "R8", "upstream word after 16 falls", got2, UPSTREAM);

    // R9: chain mode completion flag ripples from the serial input
    cur_req = "R9";
    cnv = 1'b0; step(4); sdi = 1'b0; step(4);
    sample = 16'h8001;
    cnv = 1'b1; step(4); step(CONV + 4);
    @(negedge clk);
    check(sdo_out === 1'b0 && sdo_oe === 1'b1, "R9", "flag low before upstream", sdo_out, 0);
    step(0); sdi = 1'b1; step(3);
    @(negedge clk);
    check(sdo_out === 1'b1, "R9", "upstream rise reaches output", sdo_out, 1);
    step(0); pulse(1'b1);
    read_word(got, 1'b0);
    check(got === 16'h8001, "R9", "word after flag edge", got, 16'h8001);

    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule